// File: doc/BRIEF.md
# Audio Master-Clock Ratio Detector

This block sits on the master audio clock and works out how many master-clock cycles make up one sample period. The ratio is one of four: 256, 384, 512 or 768 master-clock cycles per frame. From that ratio it produces two single-cycle clock-enable strobes for the filter and modulator logic downstream. One fires 128 times per frame and the other 64 times per frame.

In slave mode the frame clock comes from outside. The block brings it into the master-clock domain through two flops, times the interval between its rising edges, and classifies each interval. It locks once two consecutive intervals agree. In master mode the block ignores the incoming frame clock. It takes the ratio from a two-bit select, builds a frame clock with a 50% duty cycle from its own period counter, and reports lock at all times. The 768 ratio cannot be selected in master mode.

Top module: `audio_clk_ratio_det`

## Requirements
- R1: While reset is low and in the first cycle after it, `locked`, `en128`, `en64` and `frameOut` are 0 and `ratioCode` is 00.
- R2: In slave mode, the interval between rising edges of `frameIn` is counted in `clk` cycles. An interval within ±2 cycles of 256, 384, 512 or 768 is classed as code 00, 01, 10 or 11 respectively. Two consecutive intervals of the same class set `locked` and show that code on `ratioCode`.
- R3: In slave mode, an interval that falls in no class drops `locked`. So does a wait of more than 770 cycles with no rising edge. Lock returns only after two consecutive good intervals of the same class.
- R4: When a locked slave sees a good interval of a different class, `locked` drops. It returns with the new code after the next interval of that class.
- R5: While locked, `en128` is a single-cycle pulse repeating every 2, 3, 4 or 6 cycles for codes 00, 01, 10 and 11, which gives 128 pulses per frame.
- R6: `en64` pulses in the same cycle as every second `en128` pulse, which gives 64 pulses per frame and a spacing of twice the `en128` spacing.
- R7: Neither strobe pulses while `locked` is 0.
- R8: In master mode, `modeSel` 00, 01 and 10 select codes 00, 01 and 10, and 11 falls back to 00. `ratioCode` never shows 11, and `locked` is 1 from the second cycle in the mode onward.
- R9: In master mode, `frameOut` is high for N/2 cycles and low for N/2 cycles, where N is the selected ratio. In slave mode it stays 0.
- R10: In master mode, activity on `frameIn` has no effect on `frameOut` or on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = generate the frame clock, 0 = detect from `frameIn` |
| modeSel | input | 2 | Ratio select used in master mode |
| frameIn | input | 1 | External frame clock (slave mode) |
| frameOut | output | 1 | Generated frame clock (master mode) |
| ratioCode | output | 2 | Current ratio: 00=256, 01=384, 10=512, 11=768 |
| locked | output | 1 | Ratio valid and strobes running |
| en128 | output | 1 | Enable at 128 times the frame rate |
| en64 | output | 1 | Enable at 64 times the frame rate |

## Verification
Two events can land in the same cycle: the frame-edge restart of the period counter and strobe divider, and the last divider step of a frame, when both `en128` and `en64` would fire. The bench forces this with frame periods that are exact multiples of the strobe spacing. In that case the final strobe of each frame coincides with the detected edge. The bench then counts strobes over a full frame and checks that the total is exactly 128 and 64, with none dropped or doubled. The master-mode vectors test the same overlap between the generated frame wrap and the divider wrap, judged by the same counts and by the high and low widths of `frameOut`.

// File: rtl/acrd_pkg.sv
package acrd_pkg;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  typedef struct packed {
    logic   periodStart;
    logic   runStrobes;
    logic   masterGen;
    ratio_e ratio;
  } ctrl_t;

  // master-clock cycles between consecutive 128x strobes
  function automatic int unsigned stepOf(ratio_e r);
    case (r)
      RATIO_256: return 2;
      RATIO_384: return 3;
      RATIO_512: return 4;
      default:   return 6;
    endcase
  endfunction

endpackage

// File: rtl/acrd_datapath.sv
module acrd_datapath
  import acrd_pkg::*;
#(
  parameter int STROBES = 128,
  parameter int CNT_W   = 10,
  parameter int CNT_MAX = 771
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  output logic [CNT_W-1:0] periodCnt,
  output logic             frameOut,
  output logic             en128,
  output logic             en64
);

  localparam int DIV_W = 3;

  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic [CNT_W-1:0] halfCycles;
  logic             halfQ;
  logic             tick;

  // period counter: 1 on the first cycle of a frame, saturates at CNT_MAX
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.periodStart) begin
      cnt <= CNT_W'(1);
    end else if (cnt != CNT_W'(CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign periodCnt  = cnt;
  assign divLast    = DIV_W'(stepOf(ctrl.ratio) - 1);
  assign halfCycles = CNT_W'(stepOf(ctrl.ratio) * STROBES / 2);

  // strobe divider, realigned at every frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      halfQ  <= 1'b0;
    end else if (ctrl.periodStart || !ctrl.runStrobes) begin
      divCnt <= '0;
      halfQ  <= 1'b0;
    end else if (divCnt >= divLast) begin
      divCnt <= '0;
      halfQ  <= ~halfQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick     = ctrl.runStrobes && (divCnt >= divLast);
  assign en128    = tick;
  assign en64     = tick && halfQ;
  assign frameOut = ctrl.masterGen && (cnt != '0) && (cnt <= halfCycles);

  AST_EN128_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    en128 |=> !en128); // R5
  AST_EN64_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    en64 |=> !en64); // R6

endmodule

// File: rtl/acrd_ctrl.sv
module acrd_ctrl
  import acrd_pkg::*;
#(
  parameter int STROBES = 128,
  parameter int TOL     = 2,
  parameter int CNT_W   = 10,
  parameter int CNT_MAX = 771
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  logic [1:0]       modeSel,
  input  logic             frameIn,
  input  logic [CNT_W-1:0] periodCnt,
  output ctrl_t            ctrl,
  output logic [1:0]       ratioCode,
  output logic             locked
);

  localparam int NUM_RATIOS = 4;

  logic [2:0]            syncQ;
  logic                  rise;
  logic [NUM_RATIOS-1:0] hit;
  logic                  valid;
  ratio_e                code;
  ratio_e                selRatio;
  ratio_e                ratioR;
  ratio_e                prevCode;
  logic                  prevValid;
  logic                  seenEdge;
  logic                  lockedR;
  logic                  modeQ;
  logic                  modeChange;
  logic                  timeout;
  logic [CNT_W-1:0]      tgtCycles;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], frameIn};
  end
  assign rise = syncQ[1] & ~syncQ[2];

  // one window comparator per supported ratio
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : gWin
    localparam int MULT = (g == 3) ? 6 : g + 2;
    localparam int TGT  = MULT * STROBES;
    assign hit[g] = (int'(periodCnt) >= TGT - TOL) && (int'(periodCnt) <= TGT + TOL);
  end

  always_comb begin
    code = RATIO_256;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code = ratio_e'(i[1:0]);
    end
  end

  assign valid      = |hit;
  assign selRatio   = (modeSel == 2'b11) ? RATIO_256 : ratio_e'(modeSel);
  assign modeChange = masterMode != modeQ;
  assign timeout    = periodCnt == CNT_W'(CNT_MAX);
  assign tgtCycles  = CNT_W'(stepOf(ratioR) * STROBES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= 1'b0;
      seenEdge  <= 1'b0;
      prevValid <= 1'b0;
      prevCode  <= RATIO_256;
      lockedR   <= 1'b0;
      ratioR    <= RATIO_256;
    end else begin
      modeQ <= masterMode;
      if (modeChange) begin
        lockedR   <= 1'b0;
        seenEdge  <= 1'b0;
        prevValid <= 1'b0;
        if (masterMode) ratioR <= selRatio;
      end else if (modeQ) begin
        lockedR <= 1'b1;
        ratioR  <= selRatio;
      end else if (rise) begin
        seenEdge  <= 1'b1;
        prevValid <= seenEdge && valid;
        prevCode  <= code;
        if (seenEdge && valid && prevValid && (code == prevCode)) begin
          lockedR <= 1'b1;
          ratioR  <= code;
        end else begin
          lockedR <= 1'b0;
        end
      end else if (timeout) begin
        lockedR   <= 1'b0;
        prevValid <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl.periodStart = modeChange || (modeQ ? (periodCnt >= tgtCycles) : rise);
    ctrl.runStrobes  = lockedR;
    ctrl.masterGen   = modeQ;
    ctrl.ratio       = ratioR;
  end

  assign ratioCode = ratioR;
  assign locked    = lockedR;

  AST_MASTER_NO_768: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> (ratioR != RATIO_768)); // R8
  AST_LOCK_DROP_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ && !modeChange && rise && seenEdge && !valid) |=> !lockedR); // R3
  AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockedR) && !modeQ) |-> $past(rise)); // R2

endmodule

// File: rtl/audio_clk_ratio_det.sv
module audio_clk_ratio_det
  import acrd_pkg::*;
#(
  parameter int STROBES = 128,
  parameter int TOL     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterMode,
  input  logic [1:0] modeSel,
  input  logic       frameIn,
  output logic       frameOut,
  output logic [1:0] ratioCode,
  output logic       locked,
  output logic       en128,
  output logic       en64
);

  localparam int CNT_MAX = 6 * STROBES + TOL + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] periodCnt;

  acrd_ctrl #(
    .STROBES(STROBES), .TOL(TOL), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .modeSel(modeSel),
    .frameIn(frameIn), .periodCnt(periodCnt), .ctrl(ctrl),
    .ratioCode(ratioCode), .locked(locked)
  );

  acrd_datapath #(
    .STROBES(STROBES), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .periodCnt(periodCnt),
    .frameOut(frameOut), .en128(en128), .en64(en64)
  );

  AST_STROBES_NEED_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (en128 || en64) |-> locked); // R7
  AST_SLAVE_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && $past(!masterMode)) |-> !frameOut); // R9

endmodule

// File: tb/audio_clk_ratio_det_tb.sv
module audio_clk_ratio_det_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterMode = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       frameIn = 1'b0;
  logic       frameOut;
  logic [1:0] ratioCode;
  logic       locked;
  logic       en128;
  logic       en64;

  int nChecks = 0;
  int nFail   = 0;
  int framePeriod = 0;

  always #2.5 clk = ~clk;

  audio_clk_ratio_det u_dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .modeSel(modeSel),
    .frameIn(frameIn), .frameOut(frameOut), .ratioCode(ratioCode),
    .locked(locked), .en128(en128), .en64(en64)
  );

  // vector: {isMaster, sel, slavePeriod[10:0], expCode, expStep[2:0]}
  localparam int NV = 8;
  localparam logic [18:0] VECS [NV] = '{
    {1'b0, 2'd0, 11'd256, 2'd0, 3'd2},
    {1'b0, 2'd0, 11'd384, 2'd1, 3'd3},
    {1'b0, 2'd0, 11'd512, 2'd2, 3'd4},
    {1'b0, 2'd0, 11'd768, 2'd3, 3'd6},
    {1'b1, 2'd0, 11'd300, 2'd0, 3'd2},
    {1'b1, 2'd1, 11'd300, 2'd1, 3'd3},
    {1'b1, 2'd2, 11'd300, 2'd2, 3'd4},
    {1'b1, 2'd3, 11'd300, 2'd0, 3'd2}
  };

  // external frame clock generator (0 = held low)
  initial begin
    forever begin
      if (framePeriod == 0) begin
        frameIn = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = framePeriod;
        frameIn = 1'b1;
        repeat (p / 2) @(negedge clk);
        frameIn = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog (R2) actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap128(output int g);
    int k = 0;
    do begin @(negedge clk); k++; end while (!en128 && k < 2000);
    g = 0;
    do begin @(negedge clk); g++; end while (!en128 && g < 2000);
  endtask

  task automatic gap64(output int g);
    int k = 0;
    do begin @(negedge clk); k++; end while (!en64 && k < 2000);
    g = 0;
    do begin @(negedge clk); g++; end while (!en64 && g < 2000);
  endtask

  task automatic countStrobes(input int n, output int c128, output int c64);
    c128 = 0;
    c64  = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (en128) c128++;
      if (en64)  c64++;
    end
  endtask

  task automatic frameWidths(output int hi, output int lo);
    int k = 0;
    while (frameOut && k < 2000) begin @(negedge clk); k++; end
    while (!frameOut && k < 4000) begin @(negedge clk); k++; end
    hi = 0;
    while (frameOut && hi < 2000) begin @(negedge clk); hi++; end
    lo = 0;
    while (!frameOut && lo < 2000) begin @(negedge clk); lo++; end
  endtask

  initial begin
    int g, c1, c2, hi, lo;
    bit sawDrop;

    // reset state
    @(negedge clk);
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 en128 in reset", int'(en128), 0);
    chk("R1 frameOut in reset", int'(frameOut), 0);
    chk("R1 ratioCode in reset", int'(ratioCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 en64 after reset", int'(en64), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic isM;
      logic [1:0] sel, eCode;
      int per, step;
      isM   = VECS[v][18];
      sel   = VECS[v][17:16];
      per   = int'(VECS[v][15:5]);
      eCode = VECS[v][4:3];
      step  = int'(VECS[v][2:0]);
      masterMode  = isM;
      modeSel     = sel;
      framePeriod = per;
      doReset();
      if (!isM) begin
        waitCycles(4 * per + 20);
        chk("R2 slave locked", int'(locked), 1);
        chk("R2 slave code", int'(ratioCode), int'(eCode));
      end else begin
        waitCycles(20);
        chk("R8 master locked", int'(locked), 1);
        chk("R8 master code", int'(ratioCode), int'(eCode));
        // frameIn keeps toggling at an unrelated period (R10)
        frameWidths(hi, lo);
        chk("R9 R10 frameOut high", hi, step * 64);
        chk("R9 R10 frameOut low", lo, step * 64);
      end
      gap128(g);
      chk("R5 en128 spacing", g, step);
      gap64(g);
      chk("R6 en64 spacing", g, 2 * step);
      countStrobes(step * 128, c1, c2);
      chk("R5 en128 per frame", c1, 128);
      chk("R6 en64 per frame", c2, 64);
    end

    // tolerance edges
    masterMode  = 1'b0;
    framePeriod = 258;
    doReset();
    waitCycles(4 * 258 + 20);
    chk("R2 +2 tolerance lock", int'(locked), 1);
    chk("R2 +2 tolerance code", int'(ratioCode), 0);
    framePeriod = 382;
    waitCycles(5 * 382);
    chk("R2 -2 tolerance code", int'(ratioCode), 1);

    // out-of-window period drops lock and stops strobes
    framePeriod = 259;
    waitCycles(3 * 382 + 2 * 259);
    chk("R3 bad period unlock", int'(locked), 0);
    countStrobes(600, c1, c2);
    chk("R7 no en128 unlocked", c1, 0);
    chk("R7 no en64 unlocked", c2, 0);

    // relock after two good periods
    framePeriod = 256;
    waitCycles(259 + 4 * 256);
    chk("R3 relock", int'(locked), 1);

    // missing frame clock
    framePeriod = 0;
    waitCycles(1100);
    chk("R3 timeout unlock", int'(locked), 0);

    // class change while locked
    framePeriod = 256;
    waitCycles(5 * 256);
    chk("R4 pre-switch lock", int'(locked), 1);
    framePeriod = 768;
    sawDrop = 1'b0;
    for (int i = 0; i < 4 * 768; i++) begin
      @(negedge clk);
      if (!locked) sawDrop = 1'b1;
    end
    chk("R4 lock dropped on change", int'(sawDrop), 1);
    chk("R4 relocked", int'(locked), 1);
    chk("R4 new code", int'(ratioCode), 3);

    // live select change in master mode
    masterMode  = 1'b1;
    modeSel     = 2'b00;
    framePeriod = 200;
    waitCycles(20);
    modeSel = 2'b10;
    waitCycles(10);
    chk("R8 live select", int'(ratioCode), 2);
    modeSel = 2'b11;
    waitCycles(10);
    chk("R8 fallback code", int'(ratioCode), 0);

    // slave frameOut stays low
    masterMode = 1'b0;
    c1 = 0;
    waitCycles(3);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (frameOut) c1++;
    end
    chk("R9 slave frameOut low", c1, 0);

    summary();
    $finish;
  end

endmodule